// File: doc/BRIEF.md
# AAL5 Final-Cell Tail Builder

This block sits in the transmit path of a cell segmenter. It takes packet payload one byte per cycle, as a series of 48-byte cells, and passes the bytes through. For adaptation-layer-5 packets it runs a 32-bit CRC across the whole packet. When the last payload byte arrives, it fills the rest of the cell with zeros and closes the packet with an 8-byte tail. The tail is a 4-byte control/length word followed by the complemented CRC, and it ends exactly on a cell boundary. If the last cell has fewer than eight bytes left after the payload, the block adds one more cell of padding that carries the tail.

Cells from different channels may alternate on the input, one whole cell at a time. The block saves the running CRC, the tail word and the packet type for each channel at the end of every non-final cell. It reloads them when that channel's next cell begins. The tail word is captured only with the first byte of a packet. It never decides how many bytes go out. Only the upstream byte stream and its end-of-packet flag do that. Packets of other adaptation types are padded with zeros to the cell boundary and get no tail. While padding or the tail is being emitted, the block holds off input and sends one byte per cycle. It marks the last byte of every cell, and the last byte of the final cell of each packet, so that a sequencer can post completion.

Top module: `aal5_tail_builder`

## Requirements
- R1: While reset is held, and after it, out_valid is 0 and in_ready is 1.
- R2: Each accepted payload byte appears on out_data with out_valid exactly one cycle after acceptance, in input order and unchanged.
- R3: In the final cell of an adaptation-5 packet, the bytes after the payload are zero up to cell position 39. Positions 40..43 carry the tail word, bits 31:24 first; positions 44..47 carry the CRC, bits 31:24 first.
- R4: The CRC is CRC-32, polynomial 0x04C11DB7, preset to all ones, fed most significant bit first. It covers payload, padding and tail word, and it is complemented before it is sent.
- R5: If the last payload byte of an adaptation-5 packet lands at cell position 40 or later, the current cell is padded with zeros to its end. One extra cell follows with zeros in positions 0..39 and the tail in positions 40..47.
- R6: The tail word is sampled only with the start-of-packet byte, and in_tail_word on any other byte has no effect. Its low 16 bits, the length field, do not change how many bytes are emitted.
- R7: When in_aal5 is 0 at start of packet, the final cell is padded with zeros to the 48-byte boundary and carries no tail or CRC. A packet whose last byte is at position 47 gets no padding.
- R8: The running CRC, tail word and packet type are kept per channel (in_chan, sampled with the first byte of each cell). Cells of different channels may alternate without corrupting each other's result.
- R9: out_cell_end is 1 on every 48th output byte. out_pkt_end is 1 only on the last byte of a packet's final cell.
- R10: in_ready is 0 while padding or tail bytes are pending. During that time the block emits one byte on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | First byte of a packet (always at cell position 0) |
| in_eop | input | 1 | Last payload byte of a packet |
| in_aal5 | input | 1 | Packet is adaptation type 5 (sampled with in_sop) |
| in_chan | input | CH_W | Channel of the cell (sampled at cell position 0) |
| in_tail_word | input | 32 | Control (31:16) and length (15:0) tail word (sampled with in_sop) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Cell payload byte |
| out_cell_end | output | 1 | Output byte is the last of a cell |
| out_pkt_end | output | 1 | Output byte is the last of a packet's final cell |

## Verification
On every cycle, the assertions check several local rules. A stalled input always comes with an output byte on the next cycle. Padding bytes are zero. Tail bytes appear only in the last eight cell positions, and the extra-cell state appears only while padding. A packet end always falls on a cell end, and accepted bytes come out one cycle later. Whether the CRC value is correct, whether the tail word comes from the first byte only, and whether channels that alternate cells keep separate state can only be shown by the bench's scenarios. Those scenarios compare whole output cells against an independently built expected packet.

// File: rtl/aal5_tail_pkg.sv
package aal5_tail_pkg;
  typedef enum logic [1:0] {
    PH_PASS = 2'd0,
    PH_PAD  = 2'd1,
    PH_TRL  = 2'd2
  } phase_t;
endpackage

// File: rtl/aal5_crc_step.sv
module aal5_crc_step #(
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic [31:0] crc_in,
  input  logic [7:0]  data_in,
  output logic [31:0] crc_out
);
  always_comb begin
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int b = 7; b >= 0; b--) begin
      fb = c[31] ^ data_in[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_out = c;
  end
endmodule

// File: rtl/aal5_chan_store.sv
module aal5_chan_store #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [31:0]     wr_crc,
  input  logic [31:0]     wr_tail,
  input  logic            wr_aal5,
  input  logic [CH_W-1:0] rd_chan,
  output logic [31:0]     rd_crc,
  output logic [31:0]     rd_tail,
  output logic            rd_aal5
);
  logic [31:0] crc_mem  [NUM_CH];
  logic [31:0] tail_mem [NUM_CH];
  logic        aal_mem  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        crc_mem[i]  <= '1;
        tail_mem[i] <= '0;
        aal_mem[i]  <= 1'b0;
      end
    end else if (wr_en) begin
      crc_mem[wr_chan]  <= wr_crc;
      tail_mem[wr_chan] <= wr_tail;
      aal_mem[wr_chan]  <= wr_aal5;
    end
  end

  assign rd_crc  = crc_mem[rd_chan];
  assign rd_tail = tail_mem[rd_chan];
  assign rd_aal5 = aal_mem[rd_chan];
endmodule

// File: rtl/aal5_tail_builder.sv
module aal5_tail_builder
  import aal5_tail_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter int          CELL_BYTES = 48,
  parameter logic [31:0] POLY       = 32'h04C11DB7,
  localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic            in_aal5,
  input  logic [CH_W-1:0] in_chan,
  input  logic [31:0]     in_tail_word,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_cell_end,
  output logic            out_pkt_end
);
  localparam int POS_W = $clog2(CELL_BYTES);
  localparam logic [POS_W-1:0] LAST_P  = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] TAIL_P  = POS_W'(CELL_BYTES - 8);
  localparam logic [POS_W-1:0] PRE_P   = POS_W'(CELL_BYTES - 9);
  localparam logic [POS_W-1:0] CRC_P   = POS_W'(CELL_BYTES - 4);

  phase_t            phase_q, phase_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic              extra_q, extra_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [31:0]       crc_q, crc_d, tail_q, tail_d;
  logic              aal_q, aal_d;

  logic        accept, emit, cell_start, at_last, crc_hold, pkt_done, wr_en;
  logic [31:0] eff_crc, eff_tail, crc_upd, crc_fin, rd_crc, rd_tail;
  logic        eff_aal, rd_aal5;
  logic [CH_W-1:0] eff_chan;
  logic [7:0]  byte_d;
  logic [1:0]  k;

  aal5_chan_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_chan(chan_q), .wr_crc(crc_d), .wr_tail(tail_q), .wr_aal5(aal_q),
    .rd_chan(in_chan), .rd_crc(rd_crc), .rd_tail(rd_tail), .rd_aal5(rd_aal5)
  );

  aal5_crc_step #(.POLY(POLY)) u_crc (.crc_in(eff_crc), .data_in(byte_d), .crc_out(crc_upd));

  assign in_ready   = (phase_q == PH_PASS);
  assign accept     = in_valid && in_ready;
  assign emit       = accept || (phase_q != PH_PASS);
  assign cell_start = accept && (pos_q == '0);
  assign at_last    = (pos_q == LAST_P);
  assign eff_crc    = cell_start ? (in_sop ? '1 : rd_crc) : crc_q;
  assign eff_tail   = cell_start ? (in_sop ? in_tail_word : rd_tail) : tail_q;
  assign eff_aal    = cell_start ? (in_sop ? in_aal5 : rd_aal5) : aal_q;
  assign eff_chan   = cell_start ? in_chan : chan_q;
  assign k          = 2'(pos_q - TAIL_P);
  assign crc_fin    = ~crc_q;
  assign crc_hold   = (phase_q == PH_TRL) && (pos_q >= CRC_P);

  // byte selection: payload, zero fill, or tail word / CRC (most significant byte first)
  always_comb begin
    case (phase_q)
      PH_PASS: byte_d = in_data;
      PH_TRL:  byte_d = (pos_q < CRC_P) ? tail_q[{~k, 3'b000} +: 8] : crc_fin[{~k, 3'b000} +: 8];
      default: byte_d = 8'h00;
    endcase
  end

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    extra_d  = extra_q;
    pkt_done = 1'b0;
    pos_d    = pos_q;
    crc_d    = crc_q;
    if (emit) begin
      pos_d = at_last ? '0 : pos_q + POS_W'(1);
      crc_d = crc_hold ? crc_q : crc_upd;
      case (phase_q)
        PH_PASS: if (in_eop) begin
          if (eff_aal) begin
            if (pos_q == PRE_P) phase_d = PH_TRL;
            else begin
              phase_d = PH_PAD;
              extra_d = (pos_q >= TAIL_P) && !at_last;
            end
          end else if (at_last) begin
            pkt_done = 1'b1;
          end else begin
            phase_d = PH_PAD;
            extra_d = 1'b0;
          end
        end
        PH_PAD: begin
          if (at_last) begin
            if (extra_q) extra_d = 1'b0;
            else begin
              phase_d  = PH_PASS;
              pkt_done = 1'b1;
            end
          end else if (aal_q && !extra_q && (pos_q == PRE_P)) begin
            phase_d = PH_TRL;
          end
        end
        PH_TRL: if (at_last) begin
          phase_d  = PH_PASS;
          pkt_done = 1'b1;
        end
        default: phase_d = PH_PASS;
      endcase
    end
    chan_d = eff_chan;
    tail_d = eff_tail;
    aal_d  = eff_aal;
  end

  // save channel state at the end of every non-final cell
  assign wr_en = emit && at_last && !pkt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q      <= PH_PASS;
      pos_q        <= '0;
      extra_q      <= 1'b0;
      chan_q       <= '0;
      crc_q        <= '1;
      tail_q       <= '0;
      aal_q        <= 1'b0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_cell_end <= 1'b0;
      out_pkt_end  <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      pos_q        <= pos_d;
      extra_q      <= extra_d;
      chan_q       <= chan_d;
      crc_q        <= crc_d;
      tail_q       <= tail_d;
      aal_q        <= aal_d;
      out_valid    <= emit;
      out_data     <= byte_d;
      out_cell_end <= emit && at_last;
      out_pkt_end  <= pkt_done;
    end
  end

  assert_busy_emits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);
  assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAD) |=> (out_data == 8'h00));
  assert_tail_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TRL) |-> (pos_q >= TAIL_P));
  assert_extra_only_padding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    extra_q |-> (phase_q == PH_PAD));
  assert_end_on_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt_end |-> (out_cell_end && out_valid));
  assert_pass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && (out_data == $past(in_data))));
endmodule

// File: tb/sim_aal5_tail_builder.sv
`timescale 1ns/1ps
module sim_aal5_tail_builder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_aal5 = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_chan = '0;
  logic [31:0] in_tail_word = '0;
  logic in_ready, out_valid, out_cell_end, out_pkt_end;
  logic [7:0] out_data;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_b [0:511];
  int exp_n;
  logic [7:0] e1 [0:511];
  logic [7:0] e2 [0:511];
  logic [7:0] cap_d [0:1023];
  logic cap_ce [0:1023];
  logic cap_pe [0:1023];
  int ncap = 0;

  always #4 clk = ~clk;

  aal5_tail_builder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_aal5(in_aal5),
    .in_chan(in_chan), .in_tail_word(in_tail_word), .out_valid(out_valid),
    .out_data(out_data), .out_cell_end(out_cell_end), .out_pkt_end(out_pkt_end)
  );

  always @(negedge clk) if (rst_n && out_valid && ncap < 1024) begin
    cap_d[ncap] = out_data; cap_ce[ncap] = out_cell_end; cap_pe[ncap] = out_pkt_end;
    ncap = ncap + 1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    for (int b = 7; b >= 0; b--) begin
      logic fb;
      fb = c[31] ^ d[b];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(seed + i * 7);
  endfunction

  // expected packet image: payload, zero fill, tail word, complemented CRC
  task automatic build(input int len, input bit aal, input logic [31:0] tail, input int seed);
    logic [31:0] c;
    exp_n = aal ? ((len + 8 + 47) / 48) * 48 : ((len + 47) / 48) * 48;
    for (int i = 0; i < exp_n; i++) exp_b[i] = (i < len) ? pay(seed, i) : 8'h00;
    if (aal) begin
      for (int j = 0; j < 4; j++) exp_b[exp_n - 8 + j] = tail[31 - 8*j -: 8];
      c = '1;
      for (int i = 0; i < exp_n - 4; i++) c = ref_crc(c, exp_b[i]);
      c = ~c;
      for (int j = 0; j < 4; j++) exp_b[exp_n - 4 + j] = c[31 - 8*j -: 8];
    end
  endtask

  task automatic put_range(input int ch, input int len, input bit aal, input logic [31:0] tail,
                           input int seed, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = pay(seed, i); in_chan = 2'(ch); in_aal5 = aal;
      in_sop = (i == 0); in_eop = (i == len - 1);
      in_tail_word = (i == 0) ? tail : (tail ^ 32'hDEAD_BEEF ^ 32'(i)); // R6 garbage
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic idle();
    repeat (120) @(negedge clk);
  endtask

  task automatic cmp_stream(input int off, input int eoff, input int n, input bit use_e2, input string req);
    int bad = 0, first_a = 0, first_e = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] ev;
      ev = use_e2 ? e2[eoff + i] : e1[eoff + i];
      if (cap_d[off + i] !== ev) begin
        if (bad == 0) begin first_a = int'(cap_d[off + i]); first_e = int'(ev); end
        bad++;
      end
    end
    check(bad == 0, req, "output bytes", first_a, first_e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  localparam int NV = 7;
  localparam int          VL [NV] = '{1, 40, 41, 48, 88, 10, 48};
  localparam bit          VA [NV] = '{1, 1, 1, 1, 1, 0, 0};
  localparam logic [31:0] VT [NV] = '{32'hA5C3_FFFF, 32'h0102_0000, 32'h1234_0001,
                                       32'hCAFE_0030, 32'h0000_9999, 32'h7777_0002, 32'h1111_1111};
  localparam int          VN [NV] = '{48, 48, 96, 96, 96, 48, 48};

  initial begin
    logic [31:0] c;
    c = '1;
    for (int i = 0; i < 9; i++) c = ref_crc(c, 8'(8'h31 + i));
    check(~c == 32'hFC89_1918, "R4", "reference CRC of digit string", int'(~c), 32'hFC891918);

    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "idle after reset", int'({out_valid, in_ready}), 1);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      int pe_cnt, pe_at, ce_bad;
      ncap = 0;
      build(VL[v], VA[v], VT[v], 3 + v * 11);
      for (int i = 0; i < exp_n; i++) e1[i] = exp_b[i];
      put_range(v % 4, VL[v], VA[v], VT[v], 3 + v * 11, 0, VL[v]);
      idle();
      check(ncap == VN[v], VA[v] ? "R5" : "R7", "emitted byte count", ncap, VN[v]);
      cmp_stream(0, 0, VN[v], 1'b0, VA[v] ? "R3" : "R7");
      pe_cnt = 0; pe_at = -1; ce_bad = 0;
      for (int i = 0; i < ncap; i++) begin
        if (cap_pe[i]) begin pe_cnt++; pe_at = i; end
        if (cap_ce[i] != ((i % 48) == 47)) ce_bad++;
      end
      check(pe_cnt == 1 && pe_at == VN[v] - 1, "R9", "packet end position", pe_at, VN[v] - 1);
      check(ce_bad == 0, "R9", "cell end marks", ce_bad, 0);
    end

    // R10: stall right after a 1-byte packet's last byte
    ncap = 0;
    put_range(0, 1, 1'b1, 32'h0, 5, 0, 1);
    check(in_ready == 1'b0, "R10", "in_ready while filling", int'(in_ready), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10", "byte per cycle while filling", int'(out_valid), 1);
    idle();
    check(ncap == 48, "R10", "fill bytes emitted", ncap, 48);

    // R8: two channels alternating cells
    ncap = 0;
    build(100, 1'b1, 32'hAAAA_0064, 21);
    for (int i = 0; i < exp_n; i++) e1[i] = exp_b[i];
    build(60, 1'b1, 32'hBBBB_003C, 90);
    for (int i = 0; i < exp_n; i++) e2[i] = exp_b[i];
    put_range(1, 100, 1'b1, 32'hAAAA_0064, 21, 0, 48);
    put_range(2, 60, 1'b1, 32'hBBBB_003C, 90, 0, 48);
    put_range(1, 100, 1'b1, 32'hAAAA_0064, 21, 48, 96);
    put_range(2, 60, 1'b1, 32'hBBBB_003C, 90, 48, 60);
    put_range(1, 100, 1'b1, 32'hAAAA_0064, 21, 96, 100);
    idle();
    check(ncap == 240, "R8", "interleaved byte count", ncap, 240);
    cmp_stream(0, 0, 48, 1'b0, "R8");
    cmp_stream(48, 0, 48, 1'b1, "R8");
    cmp_stream(96, 48, 48, 1'b0, "R8");
    cmp_stream(144, 48, 48, 1'b1, "R8");
    cmp_stream(192, 96, 48, 1'b0, "R8");
    check(cap_pe[191] && cap_pe[239] && !cap_pe[143], "R9", "interleaved packet ends",
          int'({cap_pe[143], cap_pe[191], cap_pe[239]}), 3);

    // R1: reset in the middle of a fill
    put_range(3, 2, 1'b1, 32'h0, 7, 0, 2);
    repeat (3) @(negedge clk);
    do_reset();
    ncap = 0;
    repeat (5) @(negedge clk);
    check(ncap == 0 && in_ready == 1'b1, "R1", "no output after mid-fill reset", ncap, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule